// File: doc/BRIEF.md
# Bridge Address Window Decoder

This block keeps the forwarding windows of a bus bridge and tells the bridge, for every memory or I/O request it sees, whether to take the request. There are three windows. A memory window for 32-bit addresses is always present. An I/O window is optional and decodes either 16-bit or 32-bit I/O addresses. A prefetchable memory window is also optional and decodes either 32-bit or 64-bit addresses. Software sets the window bounds through a register port addressed by dword index (byte offset divided by four). The same port also holds the dword with the bus numbers.

The decode port takes an address, a flag for I/O space, a flag for a 64-bit address, and the direction of flow. For a request flowing downstream, the block claims it when the address lands inside a window of its space. For a request flowing upstream, the block claims it when the address misses every window of its space. The verdict is registered and appears one clock after the request. At reset every window is disabled, so nothing is forwarded downstream and everything is forwarded upstream.

Top module: `brw_decoder`

## Requirements
- R1: After reset every window is disabled. Index 8 reads 0x0000FFF0, index 7 reads 0x000001F1 and index 9 reads 0x0001FFF1. A downstream request is never claimed and an upstream request is always claimed.
- R2: Index 6 is a 32-bit read/write dword that holds the bus numbers and the secondary latency. At index 8, bits [15:4] hold the memory base (address bits [31:20]) and bits [31:20] hold the memory limit; bits [3:0] and [19:16] read 0. An index outside 6..12 reads 0 and ignores writes.
- R3: At index 7, bits [7:4] hold the I/O base (address bits [15:12]) and bits [15:12] hold the I/O limit. Nibbles [3:0] and [11:8] read 1 when 32-bit I/O decoding is configured and 0 otherwise. Bits [31:16] read 0. Index 12 holds the upper 16 bits of the base in [15:0] and of the limit in [31:16], and it is writable only in 32-bit I/O mode. Without an I/O window, indices 7 and 12 read 0.
- R4: At index 9, bits [15:4] hold the prefetchable base and bits [31:20] hold the prefetchable limit (address bits [31:20]). Nibbles [3:0] and [19:16] read 1 in 64-bit mode and 0 otherwise. Indices 10 and 11 hold the upper 32 address bits of the base and of the limit, and they are writable only in 64-bit mode.
- R5: The memory window spans base<<20 to (limit<<20)|0xFFFFF. The I/O window spans {upper16, base nibble, 0x000} to {upper16, limit nibble, 0xFFF}. The prefetchable window spans {upper32, base, 0x00000} to {upper32, limit, 0xFFFFF}. Both ends are inclusive.
- R6: A window whose full lower bound exceeds its full upper bound is disabled and never matches.
- R7: A downstream request (dec_upstream=0) is claimed when an I/O request hits the I/O window, or when a memory request hits the memory window or the prefetchable window.
- R8: An upstream request (dec_upstream=1) is claimed exactly when it misses every window of its space.
- R9: When dec_wide is 0, address bits [63:32] are taken as zero. I/O requests always use only bits [31:0]. A memory address whose bits [63:32] are nonzero can match only the prefetchable window.
- R10: dec_done is high in the cycle after dec_req was high and low otherwise. dec_claim is high only together with dec_done.
- R11: A decode requested in the same cycle as a register write is judged against the window values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | 6 | Dword index of the register access |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_idx (combinational) |
| dec_req | input | 1 | Decode request |
| dec_addr | input | 64 | Request address |
| dec_io | input | 1 | 1 = I/O space, 0 = memory space |
| dec_wide | input | 1 | 1 = 64-bit address |
| dec_upstream | input | 1 | 1 = request flows upstream |
| dec_done | output | 1 | Verdict valid, one cycle after dec_req |
| dec_claim | output | 1 | Request is claimed |

## Verification
A register write and a decode can fall in the same clock edge. In that case the decode must see the window as it was before the write. The bench sets up a memory window and then, in a single cycle, writes a value that disables it while asking for a downstream decode of the window's base. It expects a claim. A second decode right after must not be claimed, which shows that the write took effect one cycle later.

// File: rtl/brw_pkg.sv
package brw_pkg;

    localparam int BRW_IDX_W  = 6;
    localparam int BRW_ADDR_W = 64;
    localparam int BRW_NWIN   = 3;

    localparam int WIN_MEM = 0;
    localparam int WIN_IO  = 1;
    localparam int WIN_PF  = 2;

    localparam logic [BRW_IDX_W-1:0] IDX_BUS    = 6'd6;
    localparam logic [BRW_IDX_W-1:0] IDX_IO     = 6'd7;
    localparam logic [BRW_IDX_W-1:0] IDX_MEM    = 6'd8;
    localparam logic [BRW_IDX_W-1:0] IDX_PF     = 6'd9;
    localparam logic [BRW_IDX_W-1:0] IDX_PF_BUP = 6'd10;
    localparam logic [BRW_IDX_W-1:0] IDX_PF_LUP = 6'd11;
    localparam logic [BRW_IDX_W-1:0] IDX_IO_UP  = 6'd12;

    typedef struct packed {
        logic [BRW_ADDR_W-1:0] lo;
        logic [BRW_ADDR_W-1:0] hi;
    } brw_bounds_t;

endpackage

// File: rtl/brw_cfg_regs.sv
module brw_cfg_regs
    import brw_pkg::*;
#(
    parameter bit HAS_IO = 1'b1,
    parameter bit IO_32  = 1'b1,
    parameter bit HAS_PF = 1'b1,
    parameter bit PF_64  = 1'b1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr,
    input  logic [BRW_IDX_W-1:0]           idx,
    input  logic [31:0]                    wdata,
    output logic [31:0]                    rdata,
    output brw_bounds_t [BRW_NWIN-1:0]     bnd
);

    localparam logic [3:0] IO_CAP = (HAS_IO && IO_32) ? 4'h1 : 4'h0;
    localparam logic [3:0] PF_CAP = (HAS_PF && PF_64) ? 4'h1 : 4'h0;

    logic [31:0] bus_q;
    logic [11:0] mem_b_q, mem_l_q;
    logic [3:0]  io_b_q, io_l_q;
    logic [15:0] io_bu_q, io_lu_q;
    logic [11:0] pf_b_q, pf_l_q;
    logic [31:0] pf_bu_q, pf_lu_q;

    // mandatory registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q   <= '0;
            mem_b_q <= 12'hFFF;
            mem_l_q <= 12'h000;
        end else if (wr) begin
            if (idx == IDX_BUS) bus_q <= wdata;
            if (idx == IDX_MEM) begin
                mem_b_q <= wdata[15:4];
                mem_l_q <= wdata[31:20];
            end
        end
    end

    // optional I/O window storage
    generate
        if (HAS_IO) begin : g_io
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    io_b_q <= 4'hF;
                    io_l_q <= 4'h0;
                end else if (wr && idx == IDX_IO) begin
                    io_b_q <= wdata[7:4];
                    io_l_q <= wdata[15:12];
                end
            end
            if (IO_32) begin : g_io_up
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        io_bu_q <= '0;
                        io_lu_q <= '0;
                    end else if (wr && idx == IDX_IO_UP) begin
                        io_bu_q <= wdata[15:0];
                        io_lu_q <= wdata[31:16];
                    end
                end
            end else begin : g_io_noup
                assign io_bu_q = '0;
                assign io_lu_q = '0;
            end
        end else begin : g_noio
            assign io_b_q  = 4'hF;
            assign io_l_q  = 4'h0;
            assign io_bu_q = '0;
            assign io_lu_q = '0;
        end
    endgenerate

    // optional prefetchable window storage
    generate
        if (HAS_PF) begin : g_pf
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pf_b_q <= 12'hFFF;
                    pf_l_q <= 12'h000;
                end else if (wr && idx == IDX_PF) begin
                    pf_b_q <= wdata[15:4];
                    pf_l_q <= wdata[31:20];
                end
            end
            if (PF_64) begin : g_pf_up
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        pf_bu_q <= '0;
                        pf_lu_q <= '0;
                    end else if (wr) begin
                        if (idx == IDX_PF_BUP) pf_bu_q <= wdata;
                        if (idx == IDX_PF_LUP) pf_lu_q <= wdata;
                    end
                end
            end else begin : g_pf_noup
                assign pf_bu_q = '0;
                assign pf_lu_q = '0;
            end
        end else begin : g_nopf
            assign pf_b_q  = 12'hFFF;
            assign pf_l_q  = 12'h000;
            assign pf_bu_q = '0;
            assign pf_lu_q = '0;
        end
    endgenerate

    // read mux
    always_comb begin
        rdata = '0;
        unique case (idx)
            IDX_BUS:    rdata = bus_q;
            IDX_IO:     rdata = HAS_IO ? {16'h0, io_l_q, IO_CAP, io_b_q, IO_CAP} : 32'h0;
            IDX_MEM:    rdata = {mem_l_q, 4'h0, mem_b_q, 4'h0};
            IDX_PF:     rdata = HAS_PF ? {pf_l_q, PF_CAP, pf_b_q, PF_CAP} : 32'h0;
            IDX_PF_BUP: rdata = pf_bu_q;
            IDX_PF_LUP: rdata = pf_lu_q;
            IDX_IO_UP:  rdata = {io_lu_q, io_bu_q};
            default:    rdata = '0;
        endcase
    end

    // full-width window bounds
    always_comb begin
        bnd[WIN_MEM].lo = {32'h0, mem_b_q, 20'h00000};
        bnd[WIN_MEM].hi = {32'h0, mem_l_q, 20'hFFFFF};
        bnd[WIN_IO].lo  = {32'h0, io_bu_q, io_b_q, 12'h000};
        bnd[WIN_IO].hi  = {32'h0, io_lu_q, io_l_q, 12'hFFF};
        bnd[WIN_PF].lo  = {pf_bu_q, pf_b_q, 20'h00000};
        bnd[WIN_PF].hi  = {pf_lu_q, pf_l_q, 20'hFFFFF};
    end

endmodule

// File: rtl/brw_window.sv
module brw_window
    import brw_pkg::*;
#(
    parameter int AW = BRW_ADDR_W
) (
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic [AW-1:0] addr,
    output logic          hit
);

    logic enabled;

    always_comb begin
        enabled = (lo <= hi);
        hit     = enabled && (addr >= lo) && (addr <= hi);
    end

endmodule

// File: rtl/brw_claim_stage.sv
module brw_claim_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic is_io,
    input  logic upstream,
    input  logic hit_mem,
    input  logic hit_io,
    input  logic hit_pf,
    output logic done,
    output logic claim
);

    logic space_hit;

    always_comb begin
        space_hit = is_io ? hit_io : (hit_mem || hit_pf);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            claim <= 1'b0;
        end else begin
            done  <= req;
            claim <= req && (upstream ? !space_hit : space_hit);
        end
    end

endmodule

// File: rtl/brw_decoder.sv
module brw_decoder
    import brw_pkg::*;
#(
    parameter bit HAS_IO = 1'b1,
    parameter bit IO_32  = 1'b1,
    parameter bit HAS_PF = 1'b1,
    parameter bit PF_64  = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr,
    input  logic [BRW_IDX_W-1:0]  cfg_idx,
    input  logic [31:0]           cfg_wdata,
    output logic [31:0]           cfg_rdata,
    input  logic                  dec_req,
    input  logic [BRW_ADDR_W-1:0] dec_addr,
    input  logic                  dec_io,
    input  logic                  dec_wide,
    input  logic                  dec_upstream,
    output logic                  dec_done,
    output logic                  dec_claim
);

    brw_bounds_t [BRW_NWIN-1:0]  bnd;
    logic [BRW_ADDR_W-1:0]       mem_addr, io_addr;
    logic [BRW_NWIN-1:0]         win_hit;

    brw_cfg_regs #(
        .HAS_IO(HAS_IO), .IO_32(IO_32), .HAS_PF(HAS_PF), .PF_64(PF_64)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .idx   (cfg_idx),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .bnd   (bnd)
    );

    always_comb begin
        mem_addr = dec_wide ? dec_addr : {32'h0, dec_addr[31:0]};
        io_addr  = {32'h0, dec_addr[31:0]};
    end

    generate
        for (genvar w = 0; w < BRW_NWIN; w++) begin : g_win
            brw_window #(.AW(BRW_ADDR_W)) u_win (
                .lo   (bnd[w].lo),
                .hi   (bnd[w].hi),
                .addr ((w == WIN_IO) ? io_addr : mem_addr),
                .hit  (win_hit[w])
            );
        end
    endgenerate

    brw_claim_stage u_claim (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (dec_req),
        .is_io    (dec_io),
        .upstream (dec_upstream),
        .hit_mem  (win_hit[WIN_MEM]),
        .hit_io   (win_hit[WIN_IO]),
        .hit_pf   (win_hit[WIN_PF]),
        .done     (dec_done),
        .claim    (dec_claim)
    );

endmodule

// File: rtl/brw_decoder_chk.sv
module brw_decoder_chk
    import brw_pkg::*;
#(
    parameter bit HAS_IO = 1'b1,
    parameter bit IO_32  = 1'b1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [BRW_IDX_W-1:0]  cfg_idx,
    input logic [31:0]           cfg_rdata,
    input logic                  dec_req,
    input logic [BRW_ADDR_W-1:0] dec_addr,
    input logic                  dec_io,
    input logic                  dec_wide,
    input logic                  dec_done,
    input logic                  dec_claim,
    input logic [BRW_NWIN-1:0]   win_hit
);

    localparam logic [3:0] IO_NIB = (HAS_IO && IO_32) ? 4'h1 : 4'h0;

    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dec_req |=> dec_done); // R10
    AST_NO_DONE_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_req |=> !dec_done); // R10
    AST_CLAIM_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_claim |-> dec_done); // R10
    AST_IO_CAP_NIBBLES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == IDX_IO) |-> (cfg_rdata[3:0] == IO_NIB && cfg_rdata[11:8] == IO_NIB)); // R3
    AST_MEM_ZERO_NIBBLES: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == IDX_MEM) |-> (cfg_rdata[3:0] == 4'h0 && cfg_rdata[19:16] == 4'h0)); // R2
    AST_UNLISTED_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx < IDX_BUS || cfg_idx > IDX_IO_UP) |-> (cfg_rdata == 32'h0)); // R2
    AST_WIDE_SKIPS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_req && !dec_io && dec_wide && (dec_addr[63:32] != 32'h0)) |-> !win_hit[WIN_MEM]); // R9

endmodule

bind brw_decoder brw_decoder_chk #(.HAS_IO(HAS_IO), .IO_32(IO_32)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_idx   (cfg_idx),
    .cfg_rdata (cfg_rdata),
    .dec_req   (dec_req),
    .dec_addr  (dec_addr),
    .dec_io    (dec_io),
    .dec_wide  (dec_wide),
    .dec_done  (dec_done),
    .dec_claim (dec_claim),
    .win_hit   (win_hit)
);

// File: tb/brw_decoder_test.sv
`timescale 1ns/1ps
module brw_decoder_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_idx = 6'd0;
    logic [31:0] cfg_wdata = 32'h0;
    logic [31:0] cfg_rdata;
    logic        dec_req = 1'b0;
    logic [63:0] dec_addr = 64'h0;
    logic        dec_io = 1'b0;
    logic        dec_wide = 1'b0;
    logic        dec_upstream = 1'b0;
    logic        dec_done, dec_claim;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    brw_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dec_req(dec_req),
        .dec_addr(dec_addr), .dec_io(dec_io), .dec_wide(dec_wide),
        .dec_upstream(dec_upstream), .dec_done(dec_done), .dec_claim(dec_claim)
    );

    // bench-side model of writable fields
    logic [31:0] s_bus;
    logic [3:0]  s_iob, s_iol;
    logic [15:0] s_iobu, s_iolu;
    logic [11:0] s_mb, s_ml, s_pb, s_pl;
    logic [31:0] s_pbu, s_plu;

    task automatic model_reset();
        s_bus = 0; s_iob = 4'hF; s_iol = 0; s_iobu = 0; s_iolu = 0;
        s_mb = 12'hFFF; s_ml = 0; s_pb = 12'hFFF; s_pl = 0; s_pbu = 0; s_plu = 0;
    endtask

    task automatic model_write(input logic [5:0] i, input logic [31:0] d);
        case (i)
            6'd6:  s_bus = d;
            6'd7:  begin s_iob = d[7:4]; s_iol = d[15:12]; end
            6'd8:  begin s_mb = d[15:4]; s_ml = d[31:20]; end
            6'd9:  begin s_pb = d[15:4]; s_pl = d[31:20]; end
            6'd10: s_pbu = d;
            6'd11: s_plu = d;
            6'd12: begin s_iobu = d[15:0]; s_iolu = d[31:16]; end
            default: ;
        endcase
    endtask

    function automatic logic [31:0] exp_read(input logic [5:0] i);
        case (i)
            6'd6:  return s_bus;
            6'd7:  return {16'h0, s_iol, 4'h1, s_iob, 4'h1};
            6'd8:  return {s_ml, 4'h0, s_mb, 4'h0};
            6'd9:  return {s_pl, 4'h1, s_pb, 4'h1};
            6'd10: return s_pbu;
            6'd11: return s_plu;
            6'd12: return {s_iolu, s_iobu};
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic in_win(input logic [63:0] a, input logic [63:0] lo, input logic [63:0] hi);
        return (lo <= hi) && (a >= lo) && (a <= hi);
    endfunction

    function automatic logic exp_claim(input logic [63:0] a, input logic io, input logic wide, input logic up);
        logic [63:0] ea;
        logic hit;
        if (io) begin
            ea  = {32'h0, a[31:0]};
            hit = in_win(ea, {32'h0, s_iobu, s_iob, 12'h000}, {32'h0, s_iolu, s_iol, 12'hFFF});
        end else begin
            ea  = wide ? a : {32'h0, a[31:0]};
            hit = in_win(ea, {32'h0, s_mb, 20'h0}, {32'h0, s_ml, 20'hFFFFF}) ||
                  in_win(ea, {s_pbu, s_pb, 20'h0}, {s_plu, s_pl, 20'hFFFFF});
        end
        return up ? !hit : hit;
    endfunction

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [5:0] i, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = i; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
        model_write(i, d);
    endtask

    task automatic read_check(input logic [5:0] i, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_idx = i;
        #1;
        check(cfg_rdata == exp, req, {32'h0, cfg_rdata}, {32'h0, exp});
    endtask

    task automatic decode(input logic [63:0] a, input logic io, input logic wide, input logic up, input string req);
        logic e;
        e = exp_claim(a, io, wide, up);
        @(negedge clk);
        dec_req = 1'b1; dec_addr = a; dec_io = io; dec_wide = wide; dec_upstream = up;
        @(negedge clk);
        dec_req = 1'b0;
        check(dec_done == 1'b1, "R10 done", {63'h0, dec_done}, 64'h1);
        check(dec_claim == e, req, {63'h0, dec_claim}, {63'h0, e});
        @(negedge clk);
        check(dec_done == 1'b0 && dec_claim == 1'b0, "R10 idle", {62'h0, dec_done, dec_claim}, 64'h0);
    endtask

    function automatic logic [63:0] pick_addr(input logic io, input logic wide);
        logic [63:0] pts [8];
        int k;
        if (io) begin
            pts[0] = {32'h0, s_iobu, s_iob, 12'h000};
            pts[1] = {32'h0, s_iolu, s_iol, 12'hFFF};
        end else begin
            pts[0] = {32'h0, s_mb, 20'h0};
            pts[1] = {32'h0, s_ml, 20'hFFFFF};
        end
        pts[2] = {s_pbu, s_pb, 20'h0};
        pts[3] = {s_plu, s_pl, 20'hFFFFF};
        pts[4] = pts[0] - 64'd1;
        pts[5] = pts[1] + 64'd1;
        pts[6] = {$urandom, $urandom};
        pts[7] = {32'h0, $urandom};
        k = int'($urandom % 8);
        if (!wide && (k == 2 || k == 3)) return {$urandom, pts[k][31:0]};
        return pts[k];
    endfunction

    task automatic random_config();
        logic [11:0] b12, l12;
        logic [3:0]  b4, l4;
        b12 = 12'($urandom); l12 = ($urandom % 4 == 0) ? 12'($urandom) : (b12 | 12'($urandom % 64));
        write_reg(6'd8, {l12, 4'h0, b12, 4'h0});
        b12 = 12'($urandom); l12 = ($urandom % 4 == 0) ? 12'($urandom) : (b12 | 12'($urandom % 256));
        write_reg(6'd9, {l12, 4'h5, b12, 4'h5});
        write_reg(6'd10, $urandom % 3);
        write_reg(6'd11, $urandom % 3);
        b4 = 4'($urandom); l4 = ($urandom % 4 == 0) ? 4'($urandom) : (b4 | 4'($urandom % 4));
        write_reg(6'd7, {16'hBEEF, l4, 4'h0, b4, 4'h0});
        write_reg(6'd12, {16'($urandom % 2), 16'($urandom % 2)});
    endtask

    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_check(6'd8, 32'h0000FFF0, "R1 mem reset");
        read_check(6'd7, 32'h000001F1, "R1 io reset");
        read_check(6'd9, 32'h0001FFF1, "R1 pf reset");
        decode(64'h0, 1'b0, 1'b0, 1'b0, "R1 down mem no claim");
        decode(64'h1234, 1'b1, 1'b0, 1'b0, "R1 down io no claim");
        decode(64'hFFF0_0000, 1'b0, 1'b0, 1'b1, "R1 up claim");

        // R2 register map
        write_reg(6'd6, 32'hA5C3_0102);
        read_check(6'd6, 32'hA5C3_0102, "R2 bus dword");
        write_reg(6'd8, 32'hFFFF_FFFF);
        read_check(6'd8, 32'hFFF0_FFF0, "R2 mem masks");
        write_reg(6'd5, 32'hFFFF_FFFF);
        read_check(6'd5, 32'h0, "R2 unlisted idx");
        read_check(6'd13, 32'h0, "R2 unlisted idx high");
        read_check(6'd6, 32'hA5C3_0102, "R2 unlisted write ignored");

        // R3 / R4 field layouts
        write_reg(6'd7, 32'hFFFF_FFFF);
        read_check(6'd7, 32'h0000_F1F1, "R3 io masks");
        write_reg(6'd12, 32'h1234_5678);
        read_check(6'd12, 32'h1234_5678, "R3 io upper");
        write_reg(6'd9, 32'h0000_0000);
        read_check(6'd9, 32'h0001_0001, "R4 pf cap nibbles");
        write_reg(6'd10, 32'hCAFE_0001);
        read_check(6'd10, 32'hCAFE_0001, "R4 pf base upper");

        // R5 inclusive edges of memory window 0x100..0x1FF
        write_reg(6'd8, {12'h1FF, 4'h0, 12'h100, 4'h0});
        decode(64'h1000_0000, 1'b0, 1'b0, 1'b0, "R5 mem low edge");
        decode(64'h1FFF_FFFF, 1'b0, 1'b0, 1'b0, "R5 mem high edge");
        decode(64'h0FFF_FFFF, 1'b0, 1'b0, 1'b0, "R5 mem below");
        decode(64'h2000_0000, 1'b0, 1'b0, 1'b1, "R8 mem above up");

        // R9 wide address with upper bits cannot hit memory window
        decode(64'h0000_0001_1000_0000, 1'b0, 1'b1, 1'b0, "R9 wide misses mem");
        decode(64'h0000_0001_1000_0000, 1'b0, 1'b0, 1'b0, "R9 narrow drops upper");
        write_reg(6'd9, {12'h00F, 4'h0, 12'h000, 4'h0});
        write_reg(6'd10, 32'h1);
        write_reg(6'd11, 32'h1);
        decode(64'h0000_0001_00F0_0000, 1'b0, 1'b1, 1'b0, "R9 wide hits pf");
        decode(64'h0000_0001_00F0_0000, 1'b0, 1'b1, 1'b1, "R8 wide pf up");

        // R6 inverted window
        write_reg(6'd8, {12'h0FF, 4'h0, 12'h100, 4'h0});
        decode(64'h1000_0000, 1'b0, 1'b0, 1'b0, "R6 disabled mem");

        // R7 io window uses its own space
        write_reg(6'd12, 32'h0);
        write_reg(6'd7, {16'h0, 4'h3, 4'h0, 4'h2, 4'h0});
        decode(64'h2000, 1'b1, 1'b0, 1'b0, "R7 io low edge");
        decode(64'h3FFF, 1'b1, 1'b0, 1'b0, "R7 io high edge");
        decode(64'h2000, 1'b0, 1'b0, 1'b0, "R7 mem space ignores io window");
        decode(64'hFFFF_FFFF_0000_2000, 1'b1, 1'b1, 1'b0, "R9 io ignores upper");

        // R11 write and decode in the same cycle
        write_reg(6'd8, {12'h1FF, 4'h0, 12'h100, 4'h0});
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 6'd8; cfg_wdata = {12'h000, 4'h0, 12'hFFF, 4'h0};
        dec_req = 1'b1; dec_addr = 64'h1000_0000; dec_io = 1'b0; dec_wide = 1'b0; dec_upstream = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0; dec_req = 1'b0;
        check(dec_claim == 1'b1, "R11 old window used", {63'h0, dec_claim}, 64'h1);
        model_write(6'd8, {12'h000, 4'h0, 12'hFFF, 4'h0});
        decode(64'h1000_0000, 1'b0, 1'b0, 1'b0, "R11 new window after");

        // random configurations and decodes: R5 R6 R7 R8 R9
        for (int c = 0; c < 25; c++) begin
            random_config();
            for (int i = 6; i <= 12; i++) read_check(6'(i), exp_read(6'(i)), "R2 R3 R4 readback");
            for (int d = 0; d < 16; d++) begin
                logic io, wide, up;
                io = 1'($urandom); wide = 1'($urandom); up = 1'($urandom);
                decode(pick_addr(io, wide), io, wide, up, "R7 R8 random decode");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule